// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This timer block sits next to a DRAM strobe sequencer and decides when that sequencer must run a refresh cycle. When reset is released it first keeps the memory idle for a power-up pause of `PAUSE_US` microseconds. It then requests `INIT_CYCLES` warm-up cycles, one after another. After the warm-up it raises `ready`, which tells the host path that normal accesses may start. From then on it asks for one refresh every `RETENTION_US / ROWS` microseconds, so that every row is refreshed inside the retention window.

All cycle counts are derived from the `CLK_MHZ` parameter. Every request is for a self-addressed refresh, which uses the memory's internal row counter, so the scheduler supplies no row address. Warm-up cycles are requested through the same handshake as refreshes, with one request outstanding at a time.

The handshake has two signals. `rfsh_req` stays high while work is owed. The sequencer pulses `rfsh_done` once for each cycle it finishes. Every clock in which `rfsh_done` is high while a request is owed counts as one completed cycle, so the sequencer applies back-pressure just by leaving `rfsh_done` low. If the sequencer falls behind, the owed refreshes pile up in a saturating count, and `rfsh_req` stays high until that count has drained.

Top module: `rfsh_sched`

## Requirements
- R1: After reset is released, `rfsh_req` and `ready` stay low for exactly PAUSE_CYC = CLK_MHZ*PAUSE_US rising clock edges. `rfsh_req` is high after the PAUSE_CYC-th edge.
- R2: In the warm-up phase, `rfsh_req` stays high without a gap. Each clock in which `rfsh_done` is high completes one warm-up cycle.
- R3: `ready` rises right after the edge that samples the INIT_CYCLES-th warm-up completion. It then stays high until reset.
- R4: While `ready` is high, one refresh becomes owed every INTERVAL_CYC = floor(CLK_MHZ*RETENTION_US/ROWS) edges. The first one falls on the INTERVAL_CYC-th edge after `ready` rises.
- R5: While `ready` is high, `rfsh_req` is high exactly when the owed count is nonzero. Each sampled `rfsh_done` reduces the owed count by one.
- R6: Refreshes that are not acknowledged accumulate in the owed count, which saturates at OWED_MAX. Draining a saturated backlog takes exactly OWED_MAX completions.
- R7: `rfsh_done` has no effect while `rfsh_req` is low, whether during the pause or while nothing is owed. It neither shortens the pause nor cancels a later refresh.
- R8: Asserting reset clears `ready` and `rfsh_req`. Releasing it starts a full new pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_done | input | 1 | Sequencer reports one finished refresh or warm-up cycle |
| rfsh_req | output | 1 | Refresh or warm-up cycle requested |
| ready | output | 1 | Warm-up complete; normal access allowed |

## Verification
The embedded properties assume only that `rfsh_done` is a clean synchronous level. They take no position on whether it arrives while a request is pending, so a sequencer that acknowledges spuriously must still leave the block consistent. The stimulus therefore drives `rfsh_done` on falling edges. It deliberately drives `rfsh_done` during the pause and after the backlog has drained, and also holds it low for long stretches to force saturation. A behavioural model of pause, warm-up and owed count is compared against both outputs on every clock.

// File: rtl/rfsh_sched_pkg.sv
package rfsh_sched_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap = (cnt == W'(LIMIT - 1));
  assign tick = en && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  generate
    if (LIMIT > 1) begin : g_spacing
      // R4: two interval ends are never adjacent
      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
  parameter int unsigned MAX = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  localparam int unsigned W = $clog2(MAX + 1);

  logic [W-1:0] cnt;
  logic         take;

  assign take    = dec && (cnt != '0);
  assign nonzero = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, take})
        2'b10:   if (cnt != W'(MAX)) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: a full backlog stays full while more interval ends arrive
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == W'(MAX) && inc) |=> (cnt == W'(MAX)));

  // R7: an empty count is not pulled below zero by stray completions
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !inc) |=> (cnt == '0));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_sched_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PAUSE_US     = 200,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned ROWS         = 1024,
  parameter int unsigned RETENTION_US = 16000,
  parameter int unsigned OWED_MAX     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_done,
  output logic rfsh_req,
  output logic ready
);
  localparam int unsigned PAUSE_CYC    = CLK_MHZ * PAUSE_US;
  localparam int unsigned INTERVAL_CYC = (CLK_MHZ * RETENTION_US) / ROWS;
  localparam int unsigned IW           = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  phase_e        ph;
  logic [IW-1:0] init_cnt;
  logic          pause_tick;
  logic          run_tick;
  logic          owed_nz;
  logic          init_ack;
  logic          init_last;

  rfsh_interval_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ph == PH_PAUSE),
    .tick (pause_tick)
  );

  rfsh_interval_timer #(.LIMIT(INTERVAL_CYC)) u_interval (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ph == PH_RUN),
    .tick (run_tick)
  );

  rfsh_owed_counter #(.MAX(OWED_MAX)) u_owed (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (run_tick),
    .dec    (rfsh_done && (ph == PH_RUN)),
    .nonzero(owed_nz)
  );

  assign init_ack  = (ph == PH_INIT) && rfsh_done;
  assign init_last = (init_cnt == IW'(INIT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_PAUSE;
      init_cnt <= '0;
    end else begin
      case (ph)
        PH_PAUSE: if (pause_tick) ph <= PH_INIT;
        PH_INIT: begin
          if (init_ack) begin
            if (init_last) ph <= PH_RUN;
            else           init_cnt <= init_cnt + 1'b1;
          end
        end
        default: ph <= PH_RUN;
      endcase
    end
  end

  assign rfsh_req = (ph == PH_INIT) || ((ph == PH_RUN) && owed_nz);
  assign ready    = (ph == PH_RUN);

  // R3: once granted, access permission holds until reset
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R3: permission is granted only on the back of a completed cycle
  assert_ready_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(rfsh_done));

  // R2, R5: a request is never withdrawn without a completion
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !rfsh_done) |=> rfsh_req);
endmodule

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE_N    = 200;          // 1 MHz * 200 us
  localparam int INTERVAL_N = 16000 / 1024; // 15 cycles
  localparam int INIT_N     = 8;
  localparam int OWED_N     = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic rfsh_done;
  logic rfsh_req;
  logic ready;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  int m_ph, m_cyc, m_init, m_tmr, m_owed;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rfsh_sched #(
    .CLK_MHZ(1), .PAUSE_US(200), .INIT_CYCLES(INIT_N),
    .ROWS(1024), .RETENTION_US(16000), .OWED_MAX(OWED_N)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rfsh_done(rfsh_done),
    .rfsh_req(rfsh_req), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cyc = 0; m_init = 0; m_tmr = 0; m_owed = 0;
    end else begin
      case (m_ph)
        0: begin
          m_cyc++;
          if (m_cyc == PAUSE_N) m_ph = 1;
        end
        1: if (rfsh_done) begin
          m_init++;
          if (m_init == INIT_N) begin m_ph = 2; m_tmr = 0; end
        end
        default: begin
          int t, d;
          t = 0;
          m_tmr++;
          if (m_tmr == INTERVAL_N) begin t = 1; m_tmr = 0; end
          d = (rfsh_done && m_owed > 0) ? 1 : 0;
          m_owed = m_owed - d + t;
          if (m_owed > OWED_N) m_owed = OWED_N;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_req;
      string tag;
      exp_req = (m_ph == 1) || (m_ph == 2 && m_owed > 0);
      tag = (m_ph == 0) ? "R1" : (m_ph == 1) ? "R2" : "R5";
      check(rfsh_req == exp_req, tag, "model rfsh_req", int'(rfsh_req), int'(exp_req));
      check(ready == (m_ph == 2), "R3", "model ready", int'(ready), int'(m_ph == 2));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      check(0, "WATCHDOG", "run did not end", cyc, 150000);
      report();
    end
  end

  initial begin
    int k;
    rst_n = 1'b0;
    rfsh_done = 1'b0;
    repeat (4) @(negedge clk);
    check(!rfsh_req && !ready, "R8", "outputs in reset", int'(rfsh_req), 0);
    rst_n = 1'b1;

    // R1 and R7: stray completions during the pause are ignored
    for (int i = 1; i < PAUSE_N; i++) begin
      rfsh_done = (i % 2 == 1) && (i < 150);
      @(negedge clk);
    end
    rfsh_done = 1'b0;
    check(!rfsh_req, "R1", "req on last pause cycle", int'(rfsh_req), 0);
    check(!ready, "R1", "ready during pause", int'(ready), 0);
    @(negedge clk);
    check(rfsh_req, "R1", "req after pause", int'(rfsh_req), 1);

    // R2, R3: warm-up completions
    for (int i = 0; i < INIT_N; i++) begin
      check(rfsh_req, "R2", "warm-up req held", int'(rfsh_req), 1);
      rfsh_done = 1'b1;
      @(negedge clk);
      rfsh_done = 1'b0;
      check(ready == (i == INIT_N - 1), "R3", "ready vs warm-up count",
            int'(ready), int'(i == INIT_N - 1));
    end

    // R4: first refresh after one interval
    k = 0;
    while (!rfsh_req && k < 100) begin @(negedge clk); k++; end
    check(k == INTERVAL_N, "R4", "first interval", k, INTERVAL_N);

    // R4, R5: prompt acknowledge, spacing between requests
    for (int j = 0; j < 2; j++) begin
      rfsh_done = 1'b1;
      @(negedge clk);
      rfsh_done = 1'b0;
      check(!rfsh_req, "R5", "req drops after done", int'(rfsh_req), 0);
      k = 1;
      while (!rfsh_req && k < 100) begin @(negedge clk); k++; end
      check(k == INTERVAL_N, "R4", "interval spacing", k, INTERVAL_N);
    end

    // R6: stall to saturate, then drain
    repeat (9 * INTERVAL_N) @(negedge clk);
    check(rfsh_req, "R6", "req with backlog", int'(rfsh_req), 1);
    rfsh_done = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (rfsh_req && k < 20);
    check(k == OWED_N, "R6", "completions to drain", k, OWED_N);

    // R7: extra completions with nothing owed
    repeat (3) @(negedge clk);
    rfsh_done = 1'b0;
    check(!rfsh_req, "R7", "req after stray done", int'(rfsh_req), 0);
    k = 10;
    while (!rfsh_req && k < 100) begin @(negedge clk); k++; end
    check(k == INTERVAL_N, "R7", "next refresh kept on schedule", k, INTERVAL_N);
    rfsh_done = 1'b1;
    @(negedge clk);
    rfsh_done = 1'b0;
    check(!rfsh_req, "R7", "single done clears single owed", int'(rfsh_req), 0);

    // mixed acknowledge pattern, model compared every cycle
    repeat (2000) begin
      @(negedge clk);
      rfsh_done = ($urandom_range(0, 3) == 0);
    end
    rfsh_done = 1'b0;

    // R8: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!ready, "R8", "ready cleared by reset", int'(ready), 0);
    check(!rfsh_req, "R8", "req cleared by reset", int'(rfsh_req), 0);
    rst_n = 1'b1;
    for (int i = 1; i < PAUSE_N; i++) @(negedge clk);
    check(!rfsh_req, "R8", "new pause after reset", int'(rfsh_req), 0);
    @(negedge clk);
    check(rfsh_req, "R8", "req after new pause", int'(rfsh_req), 1);
    repeat (400) begin
      @(negedge clk);
      rfsh_done = ($urandom_range(0, 1) == 0);
    end
    rfsh_done = 1'b0;
    @(negedge clk);
    report();
  end
endmodule